// File: doc/BRIEF.md
# Serial Command and Fault Status Port for an Eight-Channel Switch

This block is the digital control port of an eight-channel low-side switch controller. An external SPI master lowers the select line and clocks in one command byte, sending the most significant bit first. Each bit turns one output channel on or off. While that byte moves in, the port moves out a byte of per-channel fault status. Because each device forwards the bits it receives, several devices can share one chain. The status byte is built from digital fault flags supplied by the analog section: over-temperature and over-current per channel, open-load per channel, and one global over-voltage flag.

All three serial pins are brought into the system clock domain through two-flop synchronizers. Edges are then detected on the synchronized copies:

- A falling select edge parallel-loads the status byte into the shift register.
- Each falling serial-clock edge inside a frame shifts one bit in.
- A rising select edge copies the shift register to the channel command outputs.

The serial output is driven only while the port is selected; otherwise it floats. An active-low reset clears the shift register and the command latch, so every channel is off.

Top module: `chan_switch_spi`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `cmd_o` is 0 (all channels off) and `sdo_oe_o` is 0.
- R2: While `csn_i` is high, `sdo_oe_o` is 0 and `sdo_o` is high-impedance. Serial-clock activity while `csn_i` is high changes neither `cmd_o` nor the next frame's result.
- R3: On a falling `csn_i`, the status byte is loaded and sent most significant bit first. The first bit seen on `sdo_o` before any serial-clock falling edge is status bit 7, which belongs to channel 7.
- R4: On each falling `sclk_i` edge inside a frame, the bit on `sdi_i` is shifted in at the least significant end, and the next status bit appears on `sdo_o`.
- R5: `cmd_o` changes only after a rising `csn_i`, and then takes the shift register contents: bit n drives channel n. It holds its value while a frame is in progress.
- R6: An open-load flag sets status bit n only when channel n is commanded off in `cmd_o`.
- R7: An over-temperature or over-current flag sets status bit n whatever the command for channel n.
- R8: The global over-voltage flag sets all eight status bits.
- R9: A frame whose bit count is not a multiple of 8 latches the last 8 bits received (a 12-bit frame 0xABC gives `cmd_o` = 0xBC).
- R10: In a 16-bit frame, the last 8 bits shifted out are the first 8 bits shifted in, so devices can be daisy-chained.
- R11: A reset pulse during a frame forces `cmd_o` to 0 at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; clears the shift register and the command latch |
| sclk_i | input | 1 | Serial clock from the master; idles low |
| csn_i | input | 1 | Active-low select |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out; high-impedance while deselected |
| sdo_oe_o | output | 1 | High while `sdo_o` is driven |
| ot_i | input | 8 | Per-channel over-temperature flags |
| oc_i | input | 8 | Per-channel over-current / short-to-supply flags |
| ol_i | input | 8 | Per-channel open-load flags |
| ov_i | input | 1 | Global over-voltage flag |
| cmd_o | output | 8 | Channel on/off commands; bit n drives channel n |

## Verification
The assertions check the cycle-level rules on every cycle:

- the output-enable stays low two cycles after select goes high;
- the shift register's top bit equals the status bit present on the load edge;
- each shift moves the register one place and takes in the synchronized data bit;
- the command latch changes only in the cycle after a select rising edge;
- the reset state is present at reset release.

Only the bench scenarios can show the status merge rules (open-load masking, over-voltage fan-out), the daisy-chain pass-through, latching of odd-length frames, and the reset taken mid-frame, because these depend on whole frames of stimulus.

// File: rtl/chsw_pkg.sv
package chsw_pkg;
    parameter int CHSW_NCH = 8;

    typedef enum logic {
        PH_IDLE   = 1'b0,
        PH_ACTIVE = 1'b1
    } frame_ph_e;
endpackage

// File: rtl/chsw_sync.sv
module chsw_sync #(
    parameter int          W       = 3,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    for (genvar g = 0; g < W; g++) begin : g_bit
        logic meta_q;
        logic hold_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= RST_VAL[g];
                hold_q <= RST_VAL[g];
            end else begin
                meta_q <= d_i[g];
                hold_q <= meta_q;
            end
        end
        assign q_o[g] = hold_q;
    end
endmodule

// File: rtl/chsw_fault_merge.sv
module chsw_fault_merge #(
    parameter int NCH = 8
) (
    input  logic [NCH-1:0] ot_i,
    input  logic [NCH-1:0] oc_i,
    input  logic [NCH-1:0] ol_i,
    input  logic           ov_i,
    input  logic [NCH-1:0] cmd_i,
    output logic [NCH-1:0] status_o
);
    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic ol_seen;
        // open load is only meaningful with the switch off
        assign ol_seen     = ol_i[g] & ~cmd_i[g];
        assign status_o[g] = ov_i | ot_i[g] | oc_i[g] | ol_seen;
    end
endmodule

// File: rtl/chsw_frame_core.sv
module chsw_frame_core
    import chsw_pkg::*;
#(
    parameter int NCH = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           sclk_s,
    input  logic           csn_s,
    input  logic           sdi_s,
    input  logic [NCH-1:0] status_i,
    output logic [NCH-1:0] cmd_o,
    output logic [NCH-1:0] sr_o,
    output logic           sr_msb_o,
    output logic           oe_o,
    output logic           cs_fall_o,
    output logic           cs_rise_o,
    output logic           shift_en_o
);
    typedef struct packed {
        logic           sclk_prev;
        logic           csn_prev;
        frame_ph_e      phase;
        logic [NCH-1:0] sr;
        logic [NCH-1:0] cmd;
    } core_st_t;

    core_st_t st_d, st_q;
    logic     cs_fall, cs_rise, sclk_fall, shift_en;

    always_comb begin
        st_d           = st_q;
        st_d.sclk_prev = sclk_s;
        st_d.csn_prev  = csn_s;

        cs_fall   = st_q.csn_prev & ~csn_s;
        cs_rise   = ~st_q.csn_prev & csn_s;
        sclk_fall = st_q.sclk_prev & ~sclk_s;
        shift_en  = sclk_fall & ~csn_s & ~cs_fall & (st_q.phase == PH_ACTIVE);

        if (cs_fall) begin
            st_d.sr    = status_i;
            st_d.phase = PH_ACTIVE;
        end else if (cs_rise) begin
            st_d.cmd   = st_q.sr;
            st_d.phase = PH_IDLE;
        end else if (shift_en) begin
            st_d.sr = {st_q.sr[NCH-2:0], sdi_s};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sclk_prev <= 1'b0;
            st_q.csn_prev  <= 1'b1;
            st_q.phase     <= PH_IDLE;
            st_q.sr        <= '0;
            st_q.cmd       <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cmd_o      = st_q.cmd;
    assign sr_o       = st_q.sr;
    assign sr_msb_o   = st_q.sr[NCH-1];
    assign oe_o       = ~csn_s;
    assign cs_fall_o  = cs_fall;
    assign cs_rise_o  = cs_rise;
    assign shift_en_o = shift_en;
endmodule

// File: rtl/chan_switch_spi.sv
module chan_switch_spi
    import chsw_pkg::*;
#(
    parameter int NCH = CHSW_NCH
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           sclk_i,
    input  logic           csn_i,
    input  logic           sdi_i,
    output logic           sdo_o,
    output logic           sdo_oe_o,
    input  logic [NCH-1:0] ot_i,
    input  logic [NCH-1:0] oc_i,
    input  logic [NCH-1:0] ol_i,
    input  logic           ov_i,
    output logic [NCH-1:0] cmd_o
);
    localparam int NPIN = 3;
    // pin order in the synchronizer vector: {sclk, csn, sdi}
    localparam logic [NPIN-1:0] PIN_RST = 3'b010;

    logic [NPIN-1:0] pins_s;
    logic [NCH-1:0]  status_w, cmd_w, sr_w;
    logic            sr_msb_w, oe_w, cs_fall_w, cs_rise_w, shift_en_w;

    chsw_sync #(.W(NPIN), .RST_VAL(PIN_RST)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({sclk_i, csn_i, sdi_i}),
        .q_o   (pins_s)
    );

    chsw_fault_merge #(.NCH(NCH)) u_merge (
        .ot_i     (ot_i),
        .oc_i     (oc_i),
        .ol_i     (ol_i),
        .ov_i     (ov_i),
        .cmd_i    (cmd_w),
        .status_o (status_w)
    );

    chsw_frame_core #(.NCH(NCH)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk_s     (pins_s[2]),
        .csn_s      (pins_s[1]),
        .sdi_s      (pins_s[0]),
        .status_i   (status_w),
        .cmd_o      (cmd_w),
        .sr_o       (sr_w),
        .sr_msb_o   (sr_msb_w),
        .oe_o       (oe_w),
        .cs_fall_o  (cs_fall_w),
        .cs_rise_o  (cs_rise_w),
        .shift_en_o (shift_en_w)
    );

    assign cmd_o    = cmd_w;
    assign sdo_oe_o = oe_w;
    assign sdo_o    = oe_w ? sr_msb_w : 1'bz;
endmodule

// File: rtl/chsw_checker.sv
module chsw_checker #(
    parameter int NCH = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           csn_i,
    input logic           sdo_oe_o,
    input logic [NCH-1:0] cmd_o,
    input logic [NCH-1:0] status_w,
    input logic [NCH-1:0] sr_w,
    input logic           sr_msb_w,
    input logic           sdi_s,
    input logic           cs_fall_w,
    input logic           cs_rise_w,
    input logic           shift_en_w
);
    assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (cmd_o == '0) && !sdo_oe_o);

    assert_hiz_deselected_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(csn_i, 2) |-> !sdo_oe_o);

    assert_status_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cs_fall_w) |-> sr_msb_w == $past(status_w[NCH-1]));

    assert_shift_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(shift_en_w) |-> sr_w == {$past(sr_w[NCH-2:0]), $past(sdi_s)});

    assert_cmd_on_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cmd_o) |-> $past(cs_rise_w));
endmodule

bind chan_switch_spi chsw_checker #(.NCH(NCH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .csn_i      (csn_i),
    .sdo_oe_o   (sdo_oe_o),
    .cmd_o      (cmd_o),
    .status_w   (status_w),
    .sr_w       (sr_w),
    .sr_msb_w   (sr_msb_w),
    .sdi_s      (pins_s[0]),
    .cs_fall_w  (cs_fall_w),
    .cs_rise_w  (cs_rise_w),
    .shift_en_w (shift_en_w)
);

// File: tb/tb_chan_switch_spi.sv
`timescale 1ns/1ps
module tb_chan_switch_spi;
    localparam int NCH  = 8;
    localparam int HALF = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           sclk_i = 1'b0, csn_i = 1'b1, sdi_i = 1'b0;
    logic           sdo_o, sdo_oe_o;
    logic [NCH-1:0] ot_i = '0, oc_i = '0, ol_i = '0;
    logic           ov_i = 1'b0;
    logic [NCH-1:0] cmd_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    chan_switch_spi #(.NCH(NCH)) dut (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk_i), .csn_i(csn_i), .sdi_i(sdi_i),
        .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o), .ot_i(ot_i), .oc_i(oc_i),
        .ol_i(ol_i), .ov_i(ov_i), .cmd_o(cmd_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic faults(input logic [7:0] ot, input logic [7:0] oc,
                          input logic [7:0] ol, input logic ov);
        ot_i = ot; oc_i = oc; ol_i = ol; ov_i = ov;
    endtask

    // MSB-first frame of nbits; dout holds the bits seen on sdo before each fall
    task automatic spi_xfer(input int nbits, input logic [31:0] din,
                            output logic [31:0] dout);
        dout = '0;
        @(negedge clk);
        csn_i = 1'b0;
        wait_clk(6);
        for (int i = nbits - 1; i >= 0; i--) begin
            sdi_i  = din[i];
            sclk_i = 1'b1;
            wait_clk(HALF);
            dout   = {dout[30:0], sdo_o};
            sclk_i = 1'b0;
            wait_clk(HALF);
        end
        csn_i = 1'b1;
        wait_clk(HALF);
    endtask

    task automatic t_reset();
        chk("R1 cmd after reset", cmd_o, 0);
        chk("R1 oe after reset", sdo_oe_o, 0);
    endtask

    task automatic t_deselect_clock();
        for (int i = 0; i < 8; i++) begin
            sdi_i = 1'b1; sclk_i = 1'b1; wait_clk(HALF);
            sclk_i = 1'b0; wait_clk(HALF);
            if (i == 3) chk("R2 oe while deselected", sdo_oe_o, 0);
        end
        sdi_i = 1'b0;
        chk("R2 cmd unchanged by deselected clocks", cmd_o, 0);
    endtask

    task automatic t_basic();
        logic [31:0] got;
        faults(8'h00, 8'h00, 8'h00, 1'b0);
        spi_xfer(8, 32'hA5, got);
        chk("R4 command shifted in", cmd_o, 32'hA5);
        chk("R3 clean status word", got[7:0], 32'h00);
    endtask

    task automatic t_hold();
        logic [31:0] dummy;
        @(negedge clk);
        csn_i = 1'b0;
        wait_clk(6);
        for (int i = 0; i < 8; i++) begin
            sdi_i = 1'b0; sclk_i = 1'b1; wait_clk(HALF);
            dummy[i] = sdo_o;
            sclk_i = 1'b0; wait_clk(HALF);
        end
        chk("R5 cmd holds during frame", cmd_o, 32'hA5);
        csn_i = 1'b1;
        wait_clk(HALF);
        chk("R5 cmd updates on select rise", cmd_o, 32'h00);
    endtask

    task automatic t_ot_oc();
        logic [31:0] got;
        logic [31:0] g2;
        spi_xfer(8, 32'hA5, got);
        faults(8'h81, 8'h10, 8'h00, 1'b0);
        spi_xfer(8, 32'hA5, got);
        chk("R7 ot/oc status independent of command", got[7:0], 32'h91);
        faults(8'h00, 8'h80, 8'h00, 1'b0);
        spi_xfer(1, 32'h1, g2);
        chk("R3 first bit out is channel 7 status", g2[0], 1);
    endtask

    task automatic t_ol();
        logic [31:0] got;
        faults(8'h00, 8'h00, 8'h00, 1'b0);
        spi_xfer(8, 32'hA5, got);
        faults(8'h00, 8'h00, 8'hFF, 1'b0);
        spi_xfer(8, 32'hA5, got);
        chk("R6 open load only on off channels", got[7:0], 32'h5A);
    endtask

    task automatic t_ov();
        logic [31:0] got;
        faults(8'h00, 8'h00, 8'h00, 1'b1);
        spi_xfer(8, 32'h0F, got);
        chk("R8 over-voltage sets all bits", got[7:0], 32'hFF);
        chk("R4 command with over-voltage", cmd_o, 32'h0F);
        faults(8'h00, 8'h00, 8'h00, 1'b0);
    endtask

    task automatic t_daisy();
        logic [31:0] got;
        spi_xfer(16, 32'h3CC3, got);
        chk("R10 pass-through byte", got[7:0], 32'h3C);
        chk("R10 local byte latched", cmd_o, 32'hC3);
    endtask

    task automatic t_odd();
        logic [31:0] got;
        spi_xfer(12, 32'hABC, got);
        chk("R9 12-bit frame keeps last 8", cmd_o, 32'hBC);
    endtask

    task automatic t_rst_mid();
        logic [31:0] got;
        faults(8'h00, 8'h00, 8'h00, 1'b0);
        spi_xfer(8, 32'h7E, got);
        @(negedge clk);
        csn_i = 1'b0;
        wait_clk(6);
        for (int i = 0; i < 3; i++) begin
            sdi_i = 1'b1; sclk_i = 1'b1; wait_clk(HALF);
            sclk_i = 1'b0; wait_clk(HALF);
        end
        rst_n = 1'b0;
        wait_clk(1);
        chk("R11 cmd cleared by mid-frame reset", cmd_o, 0);
        wait_clk(2);
        rst_n = 1'b1;
        wait_clk(6);
        csn_i = 1'b1;
        wait_clk(HALF);
        chk("R11 all off after frame ends", cmd_o, 0);
    endtask

    initial begin
        wait_clk(4);
        t_reset();
        rst_n = 1'b1;
        wait_clk(4);
        t_reset();
        t_deselect_clock();
        t_basic();
        t_hold();
        t_ot_oc();
        t_ol();
        t_ov();
        t_daisy();
        t_odd();
        t_rst_mid();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule